// File: doc/BRIEF.md
# Interrupt Status, Mask and Clear Unit

This unit gathers twelve single-cycle event pulses from a two-wire serial bus master core and latches each into its own bit of a raw status word. Software sees that word unmasked, sees it again ANDed with a mask register, and clears individual bits by reading a dedicated clear address for each source. Because each clear touches only its own bit, an event that lands between a status read and the clear is never lost. A combined clear address wipes every bit at once, for the rare case where that loss is acceptable.

When the transmit-abort event fires, a cause word supplied by the bus engine is ORed into an abort-cause register. That register holds its value until software reads the transmit-abort clear address or the clear-all address. A single level interrupt line, driven from a flop, is the OR of all masked status bits.

Register reads have one cycle of latency. Each read returns the value the register held before the read's own side effect.

Top module: `intc_evt_unit`

## Requirements
- R1: After reset the raw status, the mask and the abort-cause word are zero, and irq and reg_rdata are low.
- R2: A pulse on evt_pulse[i] sets raw status bit i at the next clock edge, and the bit stays set until it is cleared. Bit order from bit 0 is: receive underflow, receive overflow, receive full, transmit overflow, transmit empty, read request, transmit abort (6), receive done, activity, stop seen (9), start seen, general call (11). The raw word is read at word address 0x00.
- R3: Address 0x01 returns the raw status ANDed with the mask. The mask is read and written at address 0x02, and only its low 12 bits are stored.
- R4: A read of address 0x08+i clears raw bit i and no other bit. The read returns the bit's earlier value in bit 0, and zero in every other bit.
- R5: An event pulse that arrives in the same cycle as a clear read of its own bit wins, and the bit stays set.
- R6: A read of address 0x04 returns the earlier raw word, then clears every raw bit and the abort-cause word. Event pulses and abort captures in that same cycle still take effect.
- R7: While evt_pulse[6] is high, abort_cause is ORed into the abort-cause word. This word is read at address 0x03 and accumulates across aborts. Defined cause bits are 0 to 5, 7 and 9 to 12. Input bits 6 and 8 are never stored.
- R8: A read of address 0x0E, the transmit-abort clear, also zeroes the abort-cause word. If an abort capture happens in that same cycle, the word becomes the new cause alone.
- R9: irq equals, one cycle later, the OR of the masked status bits.
- R10: Writes to any address other than 0x02 are ignored. Reads of unmapped addresses return zero and change no state.
- R11: reg_rdata is updated one cycle after reg_rd is sampled and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clear addresses act on it |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| evt_pulse | input | 12 | One-cycle event pulses, one per source |
| abort_cause | input | 13 | Abort cause word, sampled while evt_pulse[6] is high |
| irq | output | 1 | Level interrupt, registered |

## Verification
The tests cover four kinds of pulse: isolated pulses on single sources, a pulse on every source at once, and pulses that coincide with a clear read of their own bit or with the clear-all read. Isolated pulses show that per-source clears leave neighbouring bits alone. Coincident pulses separate a design where setting wins from one where clearing wins. Repeated abort captures with overlapping and reserved cause bits show accumulation versus overwrite, and show the reserved filtering. Stepping the mask around a pending bit pins the one-cycle interrupt latency.

// File: rtl/intc_evt_pkg.sv
package intc_evt_pkg;
   // number of event sources and their bit positions
   localparam int NSRC         = 12;
   localparam int SRC_RXUNDER  = 0;
   localparam int SRC_RXOVER   = 1;
   localparam int SRC_RXFULL   = 2;
   localparam int SRC_TXOVER   = 3;
   localparam int SRC_TXEMPTY  = 4;
   localparam int SRC_RDREQ    = 5;
   localparam int SRC_TXABORT  = 6;
   localparam int SRC_RXDONE   = 7;
   localparam int SRC_ACTIVE   = 8;
   localparam int SRC_STOP     = 9;
   localparam int SRC_START    = 10;
   localparam int SRC_GENCALL  = 11;

   // abort cause word: width and defined positions (6 and 8 reserved)
   localparam int ABORT_W = 13;
   localparam logic [ABORT_W-1:0] ABORT_DEFINED = 13'h1EBF;

   // word address map
   localparam int ADR_RAW    = 0;
   localparam int ADR_MASKED = 1;
   localparam int ADR_MASK   = 2;
   localparam int ADR_ABORT  = 3;
   localparam int ADR_CLRALL = 4;
endpackage

// File: rtl/intc_src_bit.sv
module intc_src_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_o <= 1'b0;
      else if (set_i)
         q_o <= 1'b1;
      else if (clr_i)
         q_o <= 1'b0;
   end
endmodule

// File: rtl/intc_abort_cap.sv
module intc_abort_cap #(
   parameter int                W     = 13,
   parameter logic [W-1:0]      VALID = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         capture_i,
   input  logic [W-1:0] cause_i,
   input  logic         clr_i,
   output logic [W-1:0] word_o
);
   logic [W-1:0] base;

   always_comb base = clr_i ? '0 : word_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_o <= '0;
      else if (capture_i)
         word_o <= base | (cause_i & VALID);
      else if (clr_i)
         word_o <= '0;
   end
endmodule

// File: rtl/intc_reg_dec.sv
module intc_reg_dec
   import intc_evt_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5,
   parameter int CLR_BASE = 8
) (
   input  logic               rd_i,
   input  logic               wr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [NSRC-1:0]    raw_i,
   input  logic [NSRC-1:0]    mask_i,
   input  logic [ABORT_W-1:0] abort_i,
   output logic [NSRC-1:0]    clr_src_o,
   output logic               clr_all_o,
   output logic               mask_we_o,
   output logic [DATA_W-1:0]  rd_word_o
);
   localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(ADR_RAW);
   localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(ADR_MASKED);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADR_MASK);
   localparam logic [ADDR_W-1:0] A_ABORT  = ADDR_W'(ADR_ABORT);
   localparam logic [ADDR_W-1:0] A_CLRALL = ADDR_W'(ADR_CLRALL);

   assign clr_all_o = rd_i && (addr_i == A_CLRALL);
   assign mask_we_o = wr_i && (addr_i == A_MASK);

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_clr
      localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(CLR_BASE + gi);
      assign clr_src_o[gi] = rd_i && (addr_i == A_CLR);
   end

   always_comb begin
      rd_word_o = '0;
      case (addr_i)
         A_RAW:    rd_word_o[NSRC-1:0]    = raw_i;
         A_MASKED: rd_word_o[NSRC-1:0]    = raw_i & mask_i;
         A_MASK:   rd_word_o[NSRC-1:0]    = mask_i;
         A_ABORT:  rd_word_o[ABORT_W-1:0] = abort_i;
         A_CLRALL: rd_word_o[NSRC-1:0]    = raw_i;
         default:  rd_word_o = '0;
      endcase
      for (int i = 0; i < NSRC; i++) begin
         if (addr_i == ADDR_W'(CLR_BASE + i)) begin
            rd_word_o    = '0;
            rd_word_o[0] = raw_i[i];
         end
      end
   end
endmodule

// File: rtl/intc_evt_unit.sv
module intc_evt_unit
   import intc_evt_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5,
   parameter int CLR_BASE = 8,
   parameter bit IRQ_REG  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NSRC-1:0]    evt_pulse,
   input  logic [ABORT_W-1:0] abort_cause,
   output logic               irq
);
   // elaboration checks
   if (DATA_W < ABORT_W || DATA_W < NSRC) begin : g_bad_dw
      $error("DATA_W too narrow for status or abort word");
   end
   if (CLR_BASE <= ADR_CLRALL) begin : g_bad_base
      $error("clear window overlaps fixed registers");
   end
   if (CLR_BASE + NSRC > (1 << ADDR_W)) begin : g_bad_aw
      $error("ADDR_W cannot hold the clear window");
   end

   logic [NSRC-1:0]    raw_q;
   logic [NSRC-1:0]    mask_q;
   logic [ABORT_W-1:0] abort_q;
   logic [NSRC-1:0]    clr_src;
   logic               clr_all;
   logic               mask_we;
   logic [DATA_W-1:0]  rd_word;
   logic [DATA_W-1:0]  rdata_q;

   intc_reg_dec #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .CLR_BASE (CLR_BASE)
   ) u_dec (
      .rd_i      (reg_rd),
      .wr_i      (reg_wr),
      .addr_i    (reg_addr),
      .raw_i     (raw_q),
      .mask_i    (mask_q),
      .abort_i   (abort_q),
      .clr_src_o (clr_src),
      .clr_all_o (clr_all),
      .mask_we_o (mask_we),
      .rd_word_o (rd_word)
   );

   for (genvar gs = 0; gs < NSRC; gs++) begin : g_src
      intc_src_bit u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (evt_pulse[gs]),
         .clr_i (clr_src[gs] | clr_all),
         .q_o   (raw_q[gs])
      );
   end

   intc_abort_cap #(
      .W     (ABORT_W),
      .VALID (ABORT_DEFINED)
   ) u_abort (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (evt_pulse[SRC_TXABORT]),
      .cause_i   (abort_cause),
      .clr_i     (clr_src[SRC_TXABORT] | clr_all),
      .word_o    (abort_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (mask_we)
         mask_q <= reg_wdata[NSRC-1:0];
   end

   if (DATA_W > NSRC) begin : g_wd_spare
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NSRC];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (reg_rd)
         rdata_q <= rd_word;
   end
   assign reg_rdata = rdata_q;

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            irq_q <= 1'b0;
         else
            irq_q <= |(raw_q & mask_q);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(raw_q & mask_q);
   end
endmodule

// File: rtl/intc_evt_chk.sv
module intc_evt_chk
   import intc_evt_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5,
   parameter int CLR_BASE = 8,
   parameter bit IRQ_REG  = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_rd,
   input logic               reg_wr,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [DATA_W-1:0]  reg_rdata,
   input logic [NSRC-1:0]    evt_pulse,
   input logic [NSRC-1:0]    raw,
   input logic [NSRC-1:0]    mask,
   input logic [ABORT_W-1:0] abort_w,
   input logic               irq
);
   localparam logic [ADDR_W-1:0] C_LO     = ADDR_W'(CLR_BASE);
   localparam logic [ADDR_W-1:0] C_HI     = ADDR_W'(CLR_BASE + NSRC - 1);
   localparam logic [ADDR_W-1:0] C_ABORT  = ADDR_W'(CLR_BASE + SRC_TXABORT);
   localparam logic [ADDR_W-1:0] A_MASKED = ADDR_W'(ADR_MASKED);
   localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADR_MASK);
   localparam logic [ADDR_W-1:0] A_CLRALL = ADDR_W'(ADR_CLRALL);

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse != '0) |=> ((raw & $past(evt_pulse)) == $past(evt_pulse))); // R5

   AST_MASKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_MASKED) |=>
         (reg_rdata == DATA_W'($past(raw) & $past(mask)))); // R3

   AST_CLR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr >= C_LO && reg_addr <= C_HI && evt_pulse == '0) |=>
         (raw == ($past(raw) & ~(NSRC'(1) << ($past(reg_addr) - C_LO))))); // R4

   AST_CLRALL: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_CLRALL) |=> (raw == $past(evt_pulse))); // R6

   AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_pulse[SRC_TXABORT] &&
       !(reg_rd && (reg_addr == A_CLRALL || reg_addr == C_ABORT))) |=>
         $stable(abort_w)); // R7

   AST_ABORT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == C_ABORT && !evt_pulse[SRC_TXABORT]) |=>
         (abort_w == '0)); // R8

   AST_MASK_WR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr != A_MASK) |=> $stable(mask)); // R10

   if (IRQ_REG) begin : g_irq_chk
      AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         irq == $past(|(raw & mask))); // R9
   end
endmodule

bind intc_evt_unit intc_evt_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .CLR_BASE (CLR_BASE),
   .IRQ_REG  (IRQ_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_rd    (reg_rd),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .evt_pulse (evt_pulse),
   .raw       (raw_q),
   .mask      (mask_q),
   .abort_w   (abort_q),
   .irq       (irq)
);

// File: tb/sim_intc_evt_unit.sv
`timescale 1ns/1ps
module sim_intc_evt_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [11:0] evt_pulse = '0;
   logic [12:0] abort_cause = '0;
   logic        irq;

   always #2.5 clk = ~clk;

   intc_evt_unit u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr      (reg_wr),
      .reg_rd      (reg_rd),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .evt_pulse   (evt_pulse),
      .abort_cause (abort_cause),
      .irq         (irq)
   );

   typedef struct {
      logic [15:0] exp;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   int n_chk = 0, n_fail = 0;     // direct checks
   int n_sb = 0,  n_sbf = 0;      // scoreboard checks
   bit done = 1'b0;
   logic pend = 1'b0;

   // monitor: a read sampled at an edge is compared at the next falling edge
   always @(posedge clk) pend <= reg_rd;
   always @(negedge clk) begin
      if (pend) begin
         n_sb++;
         if (sb_q.size() == 0) begin
            n_sbf++;
            $display("FAIL %s: unexpected read data %h, expected none", "R11", reg_rdata);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (reg_rdata !== e.exp) begin
               n_sbf++;
               $display("FAIL %s: rdata=%h expected=%h", e.tag, reg_rdata, e.exp);
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic [11:0] e, input logic [12:0] c);
      evt_pulse = e; abort_cause = c;
      @(negedge clk);
      evt_pulse = '0; abort_cause = '0;
   endtask

   task automatic rd_evt(input logic [4:0] a, input logic [11:0] e, input logic [12:0] c,
                         input logic [15:0] exp, input string tag);
      exp_t it;
      it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      reg_addr = a; reg_rd = 1'b1; evt_pulse = e; abort_cause = c;
      @(negedge clk);
      reg_rd = 1'b0; evt_pulse = '0; abort_cause = '0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
      rd_evt(a, '0, '0, exp, tag);
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_chk + n_sb, n_fail + n_sbf);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=%h expected=%h", 16'h0, 16'h1);
      finish_run();
   end

   initial begin
      idle(3);
      chk(irq === 1'b0, "R1 irq", 16'(irq), 16'h0);
      chk(reg_rdata === 16'h0, "R1 rdata", reg_rdata, 16'h0);
      rst_n = 1'b1;
      idle(1);
      rd(5'h00, 16'h0000, "R1 raw");
      rd(5'h02, 16'h0000, "R1 mask");
      rd(5'h03, 16'h0000, "R1 abort");

      // R2: latch two sources, nothing enabled yet
      pulse(12'h204, '0);
      rd(5'h00, 16'h0204, "R2 raw after pulses");
      rd(5'h01, 16'h0000, "R3 masked with zero mask");
      chk(irq === 1'b0, "R9 irq masked off", 16'(irq), 16'h0);

      // R3: enable the receive-full source
      wr(5'h02, 16'h0004);
      rd(5'h02, 16'h0004, "R3 mask readback");
      rd(5'h01, 16'h0004, "R3 masked value");
      chk(irq === 1'b1, "R9 irq enabled", 16'(irq), 16'h1);

      // R4 + R9 latency
      rd(5'h0A, 16'h0001, "R4 clear bit2 returns old");
      idle(1);
      chk(irq === 1'b0, "R9 irq after clear", 16'(irq), 16'h0);
      pulse(12'h004, '0);
      chk(irq === 1'b0, "R9 irq one cycle late", 16'(irq), 16'h0);
      idle(1);
      chk(irq === 1'b1, "R9 irq rises", 16'(irq), 16'h1);
      rd(5'h0A, 16'h0001, "R4 clear bit2 again");
      rd(5'h00, 16'h0200, "R4 other bit kept");
      rd(5'h0B, 16'h0000, "R4 clear of idle bit3");
      rd(5'h00, 16'h0200, "R4 raw unchanged");

      // R5: set wins over its own clear
      rd_evt(5'h11, 12'h200, '0, 16'h0001, "R5 clear bit9 with pulse");
      rd(5'h00, 16'h0200, "R5 bit9 survives");

      // R7: abort accumulation, reserved bits dropped
      pulse(12'h040, 13'h0009);
      pulse(12'h040, 13'h1140);
      rd(5'h03, 16'h1009, "R7 abort accumulates");
      rd(5'h00, 16'h0240, "R2 abort status bit");

      // R8: abort clear wipes cause word
      rd(5'h0E, 16'h0001, "R8 abort clear returns old");
      rd(5'h03, 16'h0000, "R8 abort word cleared");
      rd(5'h00, 16'h0200, "R8 abort status cleared");
      pulse(12'h040, 13'h0001);
      rd(5'h03, 16'h0001, "R7 new abort");
      rd_evt(5'h0E, 12'h040, 13'h0800, 16'h0001, "R8 clear with capture");
      rd(5'h03, 16'h0800, "R8 word is new cause only");
      rd(5'h00, 16'h0240, "R5 abort bit survives");

      // R6: clear-all with a coincident event
      pulse(12'h00B, '0);
      rd_evt(5'h04, 12'h800, '0, 16'h024B, "R6 clear-all returns old raw");
      rd(5'h00, 16'h0800, "R6 only coincident bit left");
      rd(5'h03, 16'h0000, "R6 abort word cleared");
      chk(irq === 1'b0, "R9 irq with unmasked bit only", 16'(irq), 16'h0);

      // R10: ignored writes and unmapped reads
      wr(5'h00, 16'hFFFF);
      wr(5'h01, 16'hFFFF);
      wr(5'h03, 16'hFFFF);
      rd(5'h00, 16'h0800, "R10 raw not writable");
      rd(5'h02, 16'h0004, "R10 mask not touched");
      rd(5'h03, 16'h0000, "R10 abort not writable");
      rd(5'h1F, 16'h0000, "R10 unmapped high");
      rd(5'h05, 16'h0000, "R10 unmapped low");
      rd(5'h00, 16'h0800, "R10 raw after unmapped reads");
      idle(2);
      chk(reg_rdata === 16'h0800, "R11 rdata held", reg_rdata, 16'h0800);

      // all sources at once
      wr(5'h02, 16'hFFFF);
      rd(5'h02, 16'h0FFF, "R3 mask keeps 12 bits");
      pulse(12'hFFF, '0);
      rd(5'h00, 16'h0FFF, "R2 all sources");
      rd(5'h01, 16'h0FFF, "R3 all masked");
      chk(irq === 1'b1, "R9 irq all", 16'(irq), 16'h1);
      wr(5'h02, 16'h0000);
      idle(1);
      chk(irq === 1'b0, "R9 irq after mask off", 16'(irq), 16'h0);
      rd(5'h04, 16'h0FFF, "R6 clear-all full");
      rd(5'h00, 16'h0000, "R6 raw empty");

      idle(3);
      finish_run();
   end
endmodule